// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block owns the interrupt lines that a host-interface peripheral raises toward the host. These are a keyboard line, a mouse line, a system-management interrupt and four general IRQ lines. The local CPU controls each source through one enable bit. A source is raised only through a deliberate sequence. The CPU must first read the enable bit and see 0, and its next write must then put a 1 in that bit. The CPU lowers a source by writing 0 to its enable bit.

A mode input decides how data traffic takes part. In gated mode (`mode_i` = 0), a source can only be raised after the CPU has written that source's output data register. The source is lowered again when the host reads that register. In direct mode (`mode_i` = 1), the system-management and general sources depend on the enable-bit sequence alone, and host reads do not affect them. The keyboard and mouse sources behave as gated in both modes.

The system-management line is the OR of its three source bits. Each general IRQ line is the OR of the general enable bits that a static routing vector selects for it.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, all enable bits and all output lines are 0.
- R2: Enable bit 0 (keyboard) and enable bit 1 (mouse) act on data register index 0 in either mode. Each bit sets only if register 0 was written before the read-0 / write-1 sequence.
- R3: A write of 1 to an enable bit has no effect unless the most recent enable read saw that bit as 0. Any write to a bit uses up that bit's read flag.
- R4: Keyboard and mouse bits clear when the CPU writes 0 to them, or when the host reads data register 0. The host-read clear applies in either mode.
- R5: In gated mode, the gated sources need a write to their own data register before they can be set. Bit 2 and bit 5 use register 1, bit 3 and bit 6 use register 2, and bit 4 uses register 3. Without that write, a write of 1 is ignored.
- R6: In gated mode, a host read of a data register clears only the enable bits tied to that register.
- R7: In direct mode, bits 2 to 6 are set by the read-0 / write-1 sequence alone, and a CPU write of 0 clears them.
- R8: In direct mode, host reads leave bits 2 to 6 unchanged.
- R9: `smi_o` is the OR of enable bits 2, 3 and 4.
- R10: `gen_irq_o[k]` is the OR of bit 5 when `irq_route_i[2k]` is 1 and bit 6 when `irq_route_i[2k+1]` is 1.
- R11: If a host-read clear and a CPU set land in the same cycle, the bit ends cleared.
- R12: Each clear also drops the source's data-written flag. Setting the source again in gated mode needs a new data-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = gated, 1 = direct |
| cpu_en_rd_i | input | 1 | CPU reads the enable register |
| cpu_en_we_i | input | 1 | CPU writes the enable register |
| cpu_en_wmask_i | input | 7 | Bits touched by the write |
| cpu_en_wdata_i | input | 7 | Write data |
| cpu_dr_wr_i | input | 4 | CPU write strobes for data registers 0..3 |
| host_dr_rd_i | input | 4 | Host read strobes for data registers 0..3 |
| irq_route_i | input | 8 | Static routing of bits 5 and 6 onto the general lines |
| cpu_en_rdata_o | output | 7 | Enable register readback |
| kbd_irq_o | output | 1 | Keyboard interrupt |
| mouse_irq_o | output | 1 | Mouse interrupt |
| smi_o | output | 1 | System-management interrupt |
| gen_irq_o | output | 4 | General IRQ lines |

## Verification
The set sequence is driven in several shapes: with no prior read, with a read but no data write, in the complete order, and with a data write that an earlier clear has already used up. These shapes separate the read flag, the data-written flag and the mode gating. Host reads are issued per register in both modes, which shows which bits each register clears and that direct mode ignores host reads. A host read placed in the same cycle as a set write checks that the clear wins. A routing vector that maps one general line to one source, one line to the other source, one line to both and one line to neither checks the OR routing.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int unsigned NUM_EN  = 7;
  localparam int unsigned NUM_DR  = 4;
  localparam int unsigned GEN_SRC = 2;
  localparam int unsigned GEN_LSB = 5;
  localparam int unsigned SMI_LSB = 2;
  localparam int unsigned SMI_SRC = 3;
  // data register tied to each enable bit
  localparam int unsigned EN_DR_MAP [NUM_EN] = '{0, 0, 1, 2, 3, 1, 2};
  // bits that stay gated whatever the mode
  localparam logic [NUM_EN-1:0] EN_FIXED_GATED = 7'b000_0011;
endpackage

// File: rtl/hirq_src_cell.sv
module hirq_src_cell #(
  parameter bit ALWAYS_GATED = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic dw_set_i,
  input  logic host_rd_i,
  output logic en_o
);
  logic en_q, rz_q, dw_q;
  logic gated, host_clr, cpu_clr, clr, set_ok;

  always_comb begin
    gated    = ALWAYS_GATED | ~mode_i;
    host_clr = gated & host_rd_i;
    cpu_clr  = wr_i & ~wbit_i;
    clr      = host_clr | cpu_clr;
    set_ok   = wr_i & wbit_i & rz_q & (~gated | dw_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      rz_q <= 1'b0;
      dw_q <= 1'b0;
    end else begin
      if (clr)         en_q <= 1'b0;
      else if (set_ok) en_q <= 1'b1;
      // a write consumes the read-as-zero flag
      if (wr_i)        rz_q <= 1'b0;
      else if (rd_i)   rz_q <= ~en_q;
      if (clr)           dw_q <= 1'b0;
      else if (dw_set_i) dw_q <= 1'b1;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/hirq_route.sv
module hirq_route #(
  parameter int unsigned LINES = 4,
  parameter int unsigned SRCS  = 2
) (
  input  logic [SRCS-1:0]       src_i,
  input  logic [LINES*SRCS-1:0] route_i,
  output logic [LINES-1:0]      irq_o
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign irq_o[k] = |(route_i[k*SRCS +: SRCS] & src_i);
  end
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hirq_pkg::*;
#(
  parameter int unsigned GEN_LINES = 4,
  localparam int unsigned RW = GEN_LINES * GEN_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cpu_en_rd_i,
  input  logic              cpu_en_we_i,
  input  logic [NUM_EN-1:0] cpu_en_wmask_i,
  input  logic [NUM_EN-1:0] cpu_en_wdata_i,
  input  logic [NUM_DR-1:0] cpu_dr_wr_i,
  input  logic [NUM_DR-1:0] host_dr_rd_i,
  input  logic [RW-1:0]     irq_route_i,
  output logic [NUM_EN-1:0] cpu_en_rdata_o,
  output logic              kbd_irq_o,
  output logic              mouse_irq_o,
  output logic              smi_o,
  output logic [GEN_LINES-1:0] gen_irq_o
);
  logic [NUM_EN-1:0] en;

  for (genvar i = 0; i < NUM_EN; i++) begin : g_src
    hirq_src_cell #(
      .ALWAYS_GATED(EN_FIXED_GATED[i])
    ) i_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_i),
      .rd_i     (cpu_en_rd_i),
      .wr_i     (cpu_en_we_i & cpu_en_wmask_i[i]),
      .wbit_i   (cpu_en_wdata_i[i]),
      .dw_set_i (cpu_dr_wr_i[EN_DR_MAP[i]]),
      .host_rd_i(host_dr_rd_i[EN_DR_MAP[i]]),
      .en_o     (en[i])
    );
  end

  hirq_route #(
    .LINES(GEN_LINES),
    .SRCS (GEN_SRC)
  ) i_route (
    .src_i  (en[GEN_LSB +: GEN_SRC]),
    .route_i(irq_route_i),
    .irq_o  (gen_irq_o)
  );

  assign cpu_en_rdata_o = en;
  assign kbd_irq_o      = en[0];
  assign mouse_irq_o    = en[1];
  assign smi_o          = |en[SMI_LSB +: SMI_SRC];
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk #(
  parameter int unsigned GEN_LINES = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mode_i,
  input logic                   cpu_en_rd_i,
  input logic                   cpu_en_we_i,
  input logic [6:0]             cpu_en_wmask_i,
  input logic [6:0]             cpu_en_wdata_i,
  input logic [3:0]             cpu_dr_wr_i,
  input logic [3:0]             host_dr_rd_i,
  input logic [GEN_LINES*2-1:0] irq_route_i,
  input logic [6:0]             cpu_en_rdata_o,
  input logic                   kbd_irq_o,
  input logic                   mouse_irq_o,
  input logic                   smi_o,
  input logic [GEN_LINES-1:0]   gen_irq_o
);
  // R3
  kbd_set_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kbd_irq_o) |-> $past(cpu_en_we_i && cpu_en_wmask_i[0] && cpu_en_wdata_i[0]));

  // R4
  kbd_cpu_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_we_i && cpu_en_wmask_i[0] && !cpu_en_wdata_i[0]) |=> !kbd_irq_o);

  // R8
  direct_host_rd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !cpu_en_we_i) |=> $stable(cpu_en_rdata_o[6:2]));

  // R9
  smi_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o == (|cpu_en_rdata_o[4:2]));

  // R11
  host_clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_dr_rd_i[0] |=> (!kbd_irq_o && !mouse_irq_o));
endmodule

bind host_irq_ctrl hirq_ctrl_chk #(.GEN_LINES(GEN_LINES)) i_chk (.*);

// File: tb/test_host_irq_ctrl.sv
module test_host_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       cpu_en_rd_i = 1'b0;
  logic       cpu_en_we_i = 1'b0;
  logic [6:0] cpu_en_wmask_i = '0;
  logic [6:0] cpu_en_wdata_i = '0;
  logic [3:0] cpu_dr_wr_i = '0;
  logic [3:0] host_dr_rd_i = '0;
  logic [7:0] irq_route_i = 8'b0011_1001;
  logic [6:0] cpu_en_rdata_o;
  logic       kbd_irq_o, mouse_irq_o, smi_o;
  logic [3:0] gen_irq_o;

  host_irq_ctrl i_host_irq_ctrl (.*);

  always #5 clk_i = ~clk_i;

  typedef struct { string req; logic [13:0] exp; } item_t;
  item_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // expected outputs from an expected enable vector (R9, R10)
  function automatic logic [13:0] obs_of(logic [6:0] en);
    logic [3:0] g;
    for (int k = 0; k < 4; k++)
      g[k] = (irq_route_i[2*k] & en[5]) | (irq_route_i[2*k+1] & en[6]);
    return {g, |en[4:2], en[1], en[0], en};
  endfunction

  task automatic expect_en(string req, logic [6:0] en);
    item_t it;
    it.req = req;
    it.exp = obs_of(en);
    q.push_back(it);
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [13:0] act;
      it  = q.pop_front();
      act = {gen_irq_o, smi_o, mouse_irq_o, kbd_irq_o, cpu_en_rdata_o};
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%b expected=%b", it.req, act, it.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic rd();
    cpu_en_rd_i = 1'b1; step(); cpu_en_rd_i = 1'b0;
  endtask

  task automatic wr(logic [6:0] m, logic [6:0] d);
    cpu_en_we_i = 1'b1; cpu_en_wmask_i = m; cpu_en_wdata_i = d;
    step();
    cpu_en_we_i = 1'b0; cpu_en_wmask_i = '0; cpu_en_wdata_i = '0;
  endtask

  task automatic drw(int idx);
    cpu_dr_wr_i[idx] = 1'b1; step(); cpu_dr_wr_i = '0;
  endtask

  task automatic hrd(int idx);
    host_dr_rd_i[idx] = 1'b1; step(); host_dr_rd_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) step();
    rst_ni = 1'b1;
    step();
    expect_en("R1 reset", 7'b000_0000);

    wr(7'b000_0001, 7'b000_0001);
    expect_en("R3 write without read", 7'b000_0000);
    drw(0);
    wr(7'b000_0001, 7'b000_0001);
    expect_en("R3 data written but no read", 7'b000_0000);

    rd();
    wr(7'b000_0011, 7'b000_0011);
    expect_en("R2 kbd and mouse set", 7'b000_0011);

    hrd(0);
    expect_en("R4 host read clears kbd and mouse", 7'b000_0000);

    rd();
    wr(7'b000_0001, 7'b000_0001);
    expect_en("R12 data flag dropped by clear", 7'b000_0000);

    drw(0); rd();
    wr(7'b000_0001, 7'b000_0001);
    expect_en("R2 kbd set again", 7'b000_0001);
    wr(7'b000_0001, 7'b000_0000);
    expect_en("R4 cpu write 0 clears kbd", 7'b000_0000);

    rd();
    wr(7'b111_1100, 7'b111_1100);
    expect_en("R5 gated without data write", 7'b000_0000);

    drw(1); rd();
    wr(7'b111_1100, 7'b111_1100);
    expect_en("R5 R9 R10 register 1 sources", 7'b010_0100);

    drw(2); drw(3); rd();
    wr(7'b101_1000, 7'b101_1000);
    expect_en("R5 R10 registers 2 and 3", 7'b111_1100);

    hrd(1);
    expect_en("R6 host read of register 1", 7'b101_1000);

    mode_i = 1'b1;
    hrd(2); hrd(3);
    expect_en("R8 direct mode host reads", 7'b101_1000);

    wr(7'b000_1000, 7'b000_0000);
    expect_en("R7 direct mode cpu clear", 7'b101_0000);

    rd();
    wr(7'b010_0100, 7'b010_0100);
    expect_en("R7 direct mode set", 7'b111_0100);

    rd();
    wr(7'b000_0001, 7'b000_0001);
    expect_en("R2 kbd gated in direct mode", 7'b111_0100);

    mode_i = 1'b0;
    drw(0); rd();
    cpu_en_we_i = 1'b1; cpu_en_wmask_i = 7'b000_0001; cpu_en_wdata_i = 7'b000_0001;
    host_dr_rd_i[0] = 1'b1;
    step();
    cpu_en_we_i = 1'b0; cpu_en_wmask_i = '0; cpu_en_wdata_i = '0; host_dr_rd_i = '0;
    expect_en("R11 clear beats set", 7'b111_0100);

    drw(0); rd();
    wr(7'b000_0010, 7'b000_0010);
    wr(7'b000_0010, 7'b000_0010);
    expect_en("R3 flag used once", 7'b111_0110);

    step(); step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule